// File: doc/BRIEF.md
# Register Field Storage Cell

This block holds one field of a control/status register. The field has a configurable width and sits at a configurable bit offset inside a bus word. Software changes it through a write strobe, a write data word and one enable per byte lane. Hardware changes it through its own value input. A hardware enable can qualify that path when high, qualify it when low, or be left out, in which case hardware loads the field on every clock. Each access path can be removed with a parameter.

A parameter selects which of the two writers wins when both act in the same cycle. The field can be set to clear itself, so that any cycle without a write returns it to zero. It can also provide AND, OR and XOR reductions of the stored value. Reset can be synchronous or asynchronous and active high or active low, and it loads a configurable value. Address decoding and read-back multiplexing are handled by the surrounding register block.

Top module: `regfield_store`

## Requirements
- R1: While reset is at its active level, the field holds RST_VAL. In the asynchronous variant the field takes RST_VAL as soon as reset becomes active, without waiting for a clock edge.
- R2: When `sw_wr` is high and software has precedence, field bit i (bus bit FLD_LSB+i) takes `sw_wdata[FLD_LSB+i]` only if `sw_be[(FLD_LSB+i)/8]` is 1. Bits in lanes that are not enabled keep their value. The change shows on the next clock.
- R3: A cycle with `sw_wr` high and every touched lane disabled leaves the field unchanged. In that cycle, under software precedence, it also blocks the hardware load and the self-clear.
- R4: In the active-high enable mode, hardware loads `hw_wdata` only in cycles with `hw_wr_en`=1. In the active-low enable mode, it loads only in cycles with `hw_wr_en`=0.
- R5: In the mode without an enable, hardware loads `hw_wdata` on every clock.
- R6: Under software precedence, a cycle in which both writers act leaves the software result.
- R7: Under hardware precedence, a cycle in which both writers act leaves `hw_wdata`. The software lane merge applies only in cycles without a hardware load.
- R8: With self-clear enabled, the field returns to 0 after any cycle with no write, so a written 1 lasts exactly one cycle.
- R9: `fld_and`, `fld_or` and `fld_xor` equal the AND, OR and XOR reductions of the stored field when each is enabled, and are 0 otherwise.
- R10: A field built without software write access ignores `sw_wr`, `sw_wdata` and `sw_be`.
- R11: A field built without hardware read access drives `fld_q` to 0.
- R12: In a cycle with no reset, no write and no self-clear, the field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset, with polarity and timing set by parameters |
| sw_wr | input | 1 | Software write strobe for this field |
| sw_wdata | input | BUS_W | Software write data word |
| sw_be | input | BUS_W/8 | Byte lane enables, where bit k covers bus bits 8k+7..8k |
| hw_wdata | input | FLD_W | Hardware update value |
| hw_wr_en | input | 1 | Hardware write enable, with polarity set by HW_MODE |
| fld_q | output | FLD_W | Stored field value |
| fld_and | output | 1 | AND reduction of the stored field |
| fld_or | output | 1 | OR reduction of the stored field |
| fld_xor | output | 1 | XOR reduction of the stored field |

## Verification
Four configurations run side by side.
- A 12-bit field at offset 6 spans three byte lanes and uses software precedence. Single-lane, multi-lane and zero-lane software writes on it show whether each lane maps onto the correct field slice.
- A 9-bit field with hardware precedence, an active-low enable, self-clear and an asynchronous active-low reset receives writes from both sides in the same cycle. On this field, only the correct priority and clearing order match the model.
- A field without software access, loaded from hardware on every clock, receives strobes whose data differs from its hardware value. Any leak from the software path therefore changes its value.
- A field without read access must keep its output at zero.

Random byte enables and data then run against the same reference model.

// File: rtl/regfield_pkg.sv
package regfield_pkg;

    typedef enum logic [1:0] {
        HWEN_NONE = 2'd0,
        HWEN_HIGH = 2'd1,
        HWEN_LOW  = 2'd2
    } hw_en_mode_e;

    typedef enum logic {
        PREC_SW = 1'b0,
        PREC_HW = 1'b1
    } prec_e;

    typedef struct packed {
        logic all_ones;
        logic any_one;
        logic parity;
    } fld_reduce_t;

    function automatic int lane_of(input int bus_bit);
        return bus_bit / 8;
    endfunction

endpackage

// File: rtl/regfield_sw_lanes.sv
module regfield_sw_lanes
    import regfield_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int FLD_LSB  = 0,
    parameter int FLD_W    = 8,
    parameter bit SW_WR_EN = 1'b1
) (
    input  logic [FLD_W-1:0]   cur,
    input  logic               sw_wr,
    input  logic [BUS_W-1:0]   sw_wdata,
    input  logic [BUS_W/8-1:0] sw_be,
    output logic               go,
    output logic [FLD_W-1:0]   nxt
);
    logic [FLD_W-1:0] lane_mask;
    logic [FLD_W-1:0] lane_data;
    logic             unused_bus;

    assign unused_bus = ^{sw_wdata, sw_be, sw_wr};

    for (genvar i = 0; i < FLD_W; i++) begin : g_bit
        localparam int LANE = lane_of(FLD_LSB + i);
        assign lane_mask[i] = sw_be[LANE];
        assign lane_data[i] = sw_wdata[FLD_LSB + i];
    end

    if (SW_WR_EN) begin : g_sw
        assign go  = sw_wr;
        assign nxt = (cur & ~lane_mask) | (lane_data & lane_mask);
    end else begin : g_no_sw
        assign go  = 1'b0;
        assign nxt = cur;
    end

endmodule

// File: rtl/regfield_hw_gate.sv
module regfield_hw_gate
    import regfield_pkg::*;
#(
    parameter bit          HW_WR_EN = 1'b1,
    parameter hw_en_mode_e HW_MODE  = HWEN_HIGH
) (
    input  logic hw_wr_en,
    output logic hit
);
    logic unused_en;
    assign unused_en = hw_wr_en;

    if (!HW_WR_EN) begin : g_off
        assign hit = 1'b0;
    end else if (HW_MODE == HWEN_HIGH) begin : g_high
        assign hit = hw_wr_en;
    end else if (HW_MODE == HWEN_LOW) begin : g_low
        assign hit = ~hw_wr_en;
    end else begin : g_always
        assign hit = 1'b1;
    end

endmodule

// File: rtl/regfield_reduce.sv
module regfield_reduce
    import regfield_pkg::*;
#(
    parameter int FLD_W  = 8,
    parameter bit AND_EN = 1'b0,
    parameter bit OR_EN  = 1'b0,
    parameter bit XOR_EN = 1'b0
) (
    input  logic [FLD_W-1:0] q,
    output fld_reduce_t      red
);
    logic unused_q;
    assign unused_q = ^q;

    if (AND_EN) begin : g_and
        assign red.all_ones = &q;
    end else begin : g_no_and
        assign red.all_ones = 1'b0;
    end

    if (OR_EN) begin : g_or
        assign red.any_one = |q;
    end else begin : g_no_or
        assign red.any_one = 1'b0;
    end

    if (XOR_EN) begin : g_xor
        assign red.parity = ^q;
    end else begin : g_no_xor
        assign red.parity = 1'b0;
    end

endmodule

// File: rtl/regfield_store.sv
module regfield_store
    import regfield_pkg::*;
#(
    parameter int               BUS_W     = 32,
    parameter int               FLD_LSB   = 6,
    parameter int               FLD_W     = 12,
    parameter bit               SW_WR_EN  = 1'b1,
    parameter bit               HW_WR_EN  = 1'b1,
    parameter bit               HW_RD_EN  = 1'b1,
    parameter hw_en_mode_e      HW_MODE   = HWEN_HIGH,
    parameter prec_e            PREC      = PREC_SW,
    parameter bit               PULSE_EN  = 1'b0,
    parameter bit               AND_EN    = 1'b1,
    parameter bit               OR_EN     = 1'b1,
    parameter bit               XOR_EN    = 1'b1,
    parameter bit               RST_ASYNC = 1'b0,
    parameter bit               RST_LOW   = 1'b0,
    parameter logic [FLD_W-1:0] RST_VAL   = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_wr,
    input  logic [BUS_W-1:0]   sw_wdata,
    input  logic [BUS_W/8-1:0] sw_be,
    input  logic [FLD_W-1:0]   hw_wdata,
    input  logic               hw_wr_en,
    output logic [FLD_W-1:0]   fld_q,
    output logic               fld_and,
    output logic               fld_or,
    output logic               fld_xor
);
    localparam int FLD_MSB = FLD_LSB + FLD_W - 1;

    logic [FLD_W-1:0] q;
    logic [FLD_W-1:0] q_nxt;
    logic [FLD_W-1:0] sw_next;
    logic             sw_go;
    logic             hw_hit;
    logic             rst_act;
    fld_reduce_t      red;

    assign rst_act = RST_LOW ? ~rst : rst;

    regfield_sw_lanes #(
        .BUS_W(BUS_W), .FLD_LSB(FLD_LSB), .FLD_W(FLD_W), .SW_WR_EN(SW_WR_EN)
    ) u_lanes (
        .cur(q), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
        .go(sw_go), .nxt(sw_next)
    );

    regfield_hw_gate #(
        .HW_WR_EN(HW_WR_EN), .HW_MODE(HW_MODE)
    ) u_hw (
        .hw_wr_en(hw_wr_en), .hit(hw_hit)
    );

    // Priority chain: the selected writer first, then the other, then self-clear.
    always_comb begin
        q_nxt = q;
        if (PREC == PREC_SW) begin
            if (sw_go)         q_nxt = sw_next;
            else if (hw_hit)   q_nxt = hw_wdata;
            else if (PULSE_EN) q_nxt = '0;
        end else begin
            if (hw_hit)        q_nxt = hw_wdata;
            else if (sw_go)    q_nxt = sw_next;
            else if (PULSE_EN) q_nxt = '0;
        end
    end

    if (RST_ASYNC && RST_LOW) begin : g_arst_low
        always_ff @(posedge clk or negedge rst) begin
            if (!rst) q <= RST_VAL;
            else      q <= q_nxt;
        end
    end else if (RST_ASYNC) begin : g_arst_high
        always_ff @(posedge clk or posedge rst) begin
            if (rst) q <= RST_VAL;
            else     q <= q_nxt;
        end
    end else begin : g_srst
        always_ff @(posedge clk) begin
            if (rst_act) q <= RST_VAL;
            else         q <= q_nxt;
        end
    end

    if (HW_RD_EN) begin : g_rd
        assign fld_q = q;
    end else begin : g_no_rd
        assign fld_q = '0;
    end

    regfield_reduce #(
        .FLD_W(FLD_W), .AND_EN(AND_EN), .OR_EN(OR_EN), .XOR_EN(XOR_EN)
    ) u_reduce (
        .q(q), .red(red)
    );

    assign fld_and = red.all_ones;
    assign fld_or  = red.any_one;
    assign fld_xor = red.parity;

    initial begin
        assert (FLD_MSB < BUS_W) else $error("field exceeds bus word");
    end

    // R6: a software-precedence write leaves the merged lane result
    p_sw_wins_r6: assert property (@(posedge clk) disable iff (rst_act)
        (PREC == PREC_SW) && sw_go |=> q == $past(sw_next));

    // R7: a hardware-precedence load leaves the hardware value
    p_hw_wins_r7: assert property (@(posedge clk) disable iff (rst_act)
        (PREC == PREC_HW) && hw_hit |=> q == $past(hw_wdata));

    // R8: a cycle with no write clears a self-clearing field
    p_pulse_clear_r8: assert property (@(posedge clk) disable iff (rst_act)
        PULSE_EN && !sw_go && !hw_hit |=> q == '0);

    // R12: a cycle with no write keeps a plain field stable
    p_hold_idle_r12: assert property (@(posedge clk) disable iff (rst_act)
        !PULSE_EN && !sw_go && !hw_hit |=> $stable(q));

endmodule

// File: tb/regfield_store_tb.sv
module regfield_store_tb;
    import regfield_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        rst_n;
    logic        sw_wr;
    logic [31:0] sw_wdata;
    logic [3:0]  sw_be;
    logic [31:0] hw_data;
    logic        en_a;
    logic        en_b;

    logic [11:0] qa;
    logic        and_a, or_a, xor_a;
    logic [8:0]  qb;
    logic        and_b, or_b, xor_b;
    logic [7:0]  qc;
    logic        and_c, or_c, xor_c;
    logic [3:0]  qd;
    logic        and_d, or_d, xor_d;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag_a = "R1";
    string tag_b = "R1";

    logic [31:0] ma, mb, mc;

    always #10 clk = ~clk;

    regfield_store #(
        .FLD_LSB(6), .FLD_W(12), .HW_MODE(HWEN_HIGH), .PREC(PREC_SW),
        .RST_VAL(12'hA5C)
    ) u_dut (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
        .hw_wdata(hw_data[11:0]), .hw_wr_en(en_a),
        .fld_q(qa), .fld_and(and_a), .fld_or(or_a), .fld_xor(xor_a)
    );

    regfield_store #(
        .FLD_LSB(12), .FLD_W(9), .HW_MODE(HWEN_LOW), .PREC(PREC_HW),
        .PULSE_EN(1'b1), .RST_ASYNC(1'b1), .RST_LOW(1'b1), .RST_VAL(9'h1A5)
    ) u_dut_hp (
        .clk(clk), .rst(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
        .hw_wdata(hw_data[8:0]), .hw_wr_en(en_b),
        .fld_q(qb), .fld_and(and_b), .fld_or(or_b), .fld_xor(xor_b)
    );

    regfield_store #(
        .FLD_LSB(24), .FLD_W(8), .SW_WR_EN(1'b0), .HW_MODE(HWEN_NONE),
        .AND_EN(1'b0), .OR_EN(1'b0), .XOR_EN(1'b0), .RST_VAL(8'h3C)
    ) u_dut_ro (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
        .hw_wdata(hw_data[7:0]), .hw_wr_en(en_a),
        .fld_q(qc), .fld_and(and_c), .fld_or(or_c), .fld_xor(xor_c)
    );

    regfield_store #(
        .FLD_LSB(0), .FLD_W(4), .HW_RD_EN(1'b0), .HW_MODE(HWEN_NONE)
    ) u_dut_nr (
        .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_be(sw_be),
        .hw_wdata(hw_data[3:0]), .hw_wr_en(en_a),
        .fld_q(qd), .fld_and(and_d), .fld_or(or_d), .fld_xor(xor_d)
    );

    function automatic logic [31:0] merge(input logic [31:0] cur, input int lsb,
                                          input int w, input logic [31:0] d,
                                          input logic [3:0] be);
        logic [31:0] r = cur;
        for (int i = 0; i < w; i++)
            if (be[(lsb + i) / 8]) r[i] = d[lsb + i];
        return r;
    endfunction

    // Reference models
    always @(posedge clk) begin
        cycles++;
        if (rst) ma = 32'hA5C;
        else if (sw_wr) ma = merge(ma, 6, 12, sw_wdata, sw_be);
        else if (en_a) ma = {20'd0, hw_data[11:0]};
        if (rst) mc = 32'h3C;
        else     mc = {24'd0, hw_data[7:0]};
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mb = 32'h1A5;
        else if (!en_b) mb = {23'd0, hw_data[8:0]};
        else if (sw_wr) mb = merge(mb, 12, 9, sw_wdata, sw_be);
        else mb = 32'd0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(tag_a, {20'd0, qa}, ma);
        chk("R9 and", {31'd0, and_a}, {31'd0, &ma[11:0]});
        chk("R9 or", {31'd0, or_a}, {31'd0, |ma[11:0]});
        chk("R9 xor", {31'd0, xor_a}, {31'd0, ^ma[11:0]});
        chk(tag_b, {23'd0, qb}, mb);
        chk("R5,R10", {24'd0, qc}, mc);
        chk("R9 off", {29'd0, and_c, or_c, xor_c}, 32'd0);
        chk("R11", {28'd0, qd}, 32'd0);
    endtask

    task automatic drive(input logic w, input logic [3:0] be, input logic [31:0] d,
                         input logic [31:0] h, input logic ea, input logic eb);
        sw_wr = w; sw_be = be; sw_wdata = d; hw_data = h; en_a = ea; en_b = eb;
        step();
    endtask

    initial begin
        rst = 1'b1; rst_n = 1'b0;
        sw_wr = 0; sw_be = 0; sw_wdata = 0; hw_data = 0; en_a = 0; en_b = 1;
        repeat (3) step();
        chk("R1 sync", {20'd0, qa}, 32'hA5C);
        chk("R1 async", {23'd0, qb}, 32'h1A5);
        rst = 1'b0; rst_n = 1'b1;
        tag_a = "R12"; tag_b = "R8";
        drive(0, 4'h0, 32'h0, 32'h0, 0, 1);
        // R2: single-lane and multi-lane writes on a field straddling lanes
        tag_a = "R2"; tag_b = "R7";
        drive(1, 4'b0001, 32'hFFFF_FFFF, 32'h0000_0123, 0, 1);
        drive(1, 4'b0010, 32'h0000_0000, 32'h0000_0456, 0, 1);
        drive(1, 4'b0100, 32'hFFFF_FFFF, 32'h0000_0789, 0, 1);
        drive(1, 4'b0111, 32'h0F0F_5A5A, 32'h0000_0ABC, 0, 0);
        drive(1, 4'b1000, 32'hFFFF_FFFF, 32'h0000_0111, 0, 1);
        // R12: idle hold (R4: active-low enable loads B)
        tag_a = "R12"; tag_b = "R4";
        drive(0, 4'hF, 32'hFFFF_FFFF, 32'h0000_0155, 0, 0);
        drive(0, 4'hF, 32'hFFFF_FFFF, 32'h0000_0022, 0, 0);
        // R3: strobe with no lanes blocks the hardware load and the clear
        tag_a = "R3"; tag_b = "R3";
        drive(1, 4'b0000, 32'hFFFF_FFFF, 32'h0000_0FFF, 1, 1);
        chk("R3 A unchanged", {20'd0, qa}, ma);
        // R4: active-high enable loads A; B clears (R8)
        tag_a = "R4"; tag_b = "R8";
        drive(0, 4'h0, 32'h0, 32'h0000_0C3A, 1, 1);
        chk("R4 A loaded", {20'd0, qa}, 32'hC3A);
        chk("R8 B cleared", {23'd0, qb}, 32'd0);
        tag_a = "R12"; tag_b = "R4";
        drive(0, 4'h0, 32'h0, 32'h0000_01F0, 0, 0);
        chk("R4 B loaded", {23'd0, qb}, 32'h1F0);
        // R6 / R7: both writers in one cycle
        tag_a = "R6"; tag_b = "R7";
        drive(1, 4'hF, 32'h0001_5540, 32'h0000_00AA, 1, 0);
        chk("R6 A sw result", {20'd0, qa}, {20'd0, 12'h555});
        chk("R7 B hw result", {23'd0, qb}, 32'h0AA);
        // R8: software writes ones into B, lasting one cycle
        tag_a = "R2"; tag_b = "R8";
        drive(1, 4'hF, 32'h001F_F000, 32'h0, 0, 1);
        chk("R8 B set", {23'd0, qb}, 32'h1FF);
        drive(0, 4'h0, 32'h0, 32'h0, 0, 1);
        chk("R8 B one cycle", {23'd0, qb}, 32'd0);
        // R9 all-ones pattern on A
        tag_a = "R9";
        drive(1, 4'hF, 32'h0003_FFC0, 32'h0, 0, 1);
        chk("R9 and high", {31'd0, and_a}, 32'd1);
        // R1: synchronous reset mid-run, asynchronous reset off-edge
        tag_a = "R1";
        rst = 1'b1;
        drive(0, 4'h0, 32'h0, 32'h0, 0, 1);
        rst = 1'b0;
        #5 rst_n = 1'b0;
        #1 chk("R1 async immediate", {23'd0, qb}, 32'h1A5);
        tag_b = "R1";
        step();
        rst_n = 1'b1;
        // random traffic
        tag_a = "R2"; tag_b = "R7";
        for (int k = 0; k < 300; k++)
            drive($urandom_range(0, 1), 4'($urandom), $urandom, $urandom,
                  1'($urandom), 1'($urandom));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule